// File: doc/BRIEF.md
# Barrel shifter with carry flag

This block is the shift path of a processor ALU. It takes a 32-bit operand, a 5-bit shift amount and a 2-bit operation code, and in the same cycle it returns the shifted word and four condition flags: zero, sign, carry and overflow. It supports three operations. A logical left shift fills the vacated low bits with zeros. A logical right shift fills the vacated high bits with zeros. An arithmetic right shift fills the vacated high bits with copies of the operand's top bit. The decoder that instantiates the block decides whether the amount comes from a register or from an immediate field. The block sees only the amount itself.

The carry flag holds the last bit pushed out of the word. Which operand bit that is depends on the direction and on the amount. When the amount is zero, no bit leaves the word, so carry reads 0 and the result equals the operand. The block contains no state. The datapath is a chain of log2(width) multiplexer stages, and each stage shifts by a power of two. Left shifts run through the same right-shifting chain by mirroring the word on the way in and mirroring it back on the way out.

Top module: `shf_unit`

## Requirements
- R1: With op_i = 2'b00 (logical left), result_o equals opnd_i shifted left by amount_i bits, with zeros entering at bit 0.
- R2: With op_i = 2'b01 (logical right), result_o equals opnd_i shifted right by amount_i bits, with zeros entering at bit 31.
- R3: With op_i = 2'b10 or 2'b11 (arithmetic right; the two codes behave identically), result_o equals opnd_i shifted right by amount_i bits, with every vacated bit filled with opnd_i[31].
- R4: For a left shift by n, where n is not zero, carry_o equals opnd_i[32 - n].
- R5: For either right shift by n, where n is not zero, carry_o equals opnd_i[n - 1].
- R6: When amount_i is zero, carry_o is 0 and result_o equals opnd_i, for every operation code.
- R7: zero_o is 1 exactly when all 32 bits of result_o are 0.
- R8: sign_o equals result_o[31].
- R9: ovf_o is 0 for every combination of inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| amount_i | input | 5 | Shift amount, 0 to 31 |
| op_i | input | 2 | 00 logical left, 01 logical right, 1x arithmetic right |
| result_o | output | 32 | Shifted word |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Top bit of the result |
| carry_o | output | 1 | Last bit shifted out; 0 when the amount is zero |
| ovf_o | output | 1 | Overflow flag, always cleared |

## Verification
The embedded assertions are re-evaluated whenever an input changes. They compare the chained multiplexer result against a direct shift expression for every operation. They check that carry matches the operand bit selected by the amount, that a zero amount gives carry 0 and an unchanged word, and that overflow stays clear. Some behaviours can only be shown by the bench's scenarios. These are that both arithmetic codes fill with the sign bit, and the extreme amounts 1 and 31 on operands with a single bit set. Also bench-only is the zero flag on results that become zero only because every set bit was shifted out. The random phase covers a broad mix of operands and amounts.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned SHF_WIDTH = 32;
    localparam int unsigned SHF_AMT_W = $clog2(SHF_WIDTH);

    // Operation codes; bit 1 alone selects the arithmetic fill.
    typedef enum logic [1:0] {
        SHF_LSL     = 2'b00,
        SHF_LSR     = 2'b01,
        SHF_ASR     = 2'b10,
        SHF_ASR_ALT = 2'b11
    } shf_op_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } shf_flags_t;

endpackage

// File: rtl/shf_stage.sv
// One multiplexer level of the right-shifting chain: moves the lane
// right by DIST places when enabled, pulling in the fill bit.
module shf_stage #(
    parameter int unsigned LANE_W = 33,
    parameter int unsigned DIST   = 1
) (
    input  logic [LANE_W-1:0] lane_i,
    input  logic              en_i,
    input  logic              fill_i,
    output logic [LANE_W-1:0] lane_o
);

    logic [LANE_W-1:0] moved;

    always_comb begin
        moved = {{DIST{fill_i}}, lane_i[LANE_W-1:DIST]};
        lane_o = en_i ? moved : lane_i;
    end

endmodule

// File: rtl/shf_core.sv
// Log-stage shifter. The word is widened by one guard bit below bit 0;
// after the chain the guard holds the last bit pushed out (0 when no
// shift happened). Left shifts are done by mirroring in and out.
module shf_core #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AMT_W  = $clog2(WIDTH),
    localparam int unsigned LANE_W = WIDTH + 1
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic             left_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] data_o,
    output logic             carry_o
);

    logic [WIDTH-1:0]  mirror_in;
    logic [WIDTH-1:0]  mirror_out;
    logic [WIDTH-1:0]  staged_in;
    logic [WIDTH-1:0]  staged_out;
    logic              fill_bit;
    logic [LANE_W-1:0] lane [AMT_W+1];

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_mirror
            assign mirror_in[gi]  = data_i[WIDTH-1-gi];
            assign mirror_out[gi] = staged_out[WIDTH-1-gi];
        end
    endgenerate

    assign staged_in = left_i ? mirror_in : data_i;
    assign fill_bit  = arith_i & ~left_i & data_i[WIDTH-1];
    assign lane[0]   = {staged_in, 1'b0};

    generate
        for (gi = 0; gi < AMT_W; gi++) begin : g_level
            shf_stage #(
                .LANE_W(LANE_W),
                .DIST  (2 ** gi)
            ) u_stage (
                .lane_i(lane[gi]),
                .en_i  (amount_i[gi]),
                .fill_i(fill_bit),
                .lane_o(lane[gi+1])
            );
        end
    endgenerate

    assign staged_out = lane[AMT_W][LANE_W-1:1];
    assign data_o     = left_i ? mirror_out : staged_out;
    assign carry_o    = lane[AMT_W][0];

    // Guard bit against a direct index of the operand.
    always_comb begin
        if (amount_i != '0) begin
            if (left_i) begin
                p_left_carry_r4: assert (carry_o == data_i[WIDTH - int'(amount_i)]);
            end else begin
                p_right_carry_r5: assert (carry_o == data_i[int'(amount_i) - 1]);
            end
        end
    end

endmodule

// File: rtl/shf_flags.sv
// Condition flags derived from the finished word.
module shf_flags #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0]          word_i,
    input  logic                      carry_i,
    output shf_pkg::shf_flags_t       flags_o
);

    always_comb begin
        flags_o.zero  = ~|word_i;
        flags_o.sign  = word_i[WIDTH-1];
        flags_o.carry = carry_i;
        flags_o.ovf   = 1'b0;
    end

    always_comb begin
        if (flags_o.zero) begin
            p_zero_means_empty_r7: assert (word_i == '0);
        end
        p_no_overflow_r9: assert (!flags_o.ovf);
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int unsigned WIDTH = SHF_WIDTH,
    localparam int unsigned AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             sign_o,
    output logic             carry_o,
    output logic             ovf_o
);

    shf_op_e    op_sel;
    logic       go_left;
    logic       go_arith;
    logic [WIDTH-1:0] word;
    logic       out_bit;
    shf_flags_t flags;

    always_comb begin
        op_sel   = shf_op_e'(op_i);
        go_left  = 1'b0;
        go_arith = 1'b0;
        unique case (op_sel)
            SHF_LSL:     go_left  = 1'b1;
            SHF_LSR:     go_arith = 1'b0;
            SHF_ASR,
            SHF_ASR_ALT: go_arith = 1'b1;
            default:     go_left  = 1'b0;
        endcase
    end

    shf_core #(.WIDTH(WIDTH)) u_core (
        .data_i  (opnd_i),
        .amount_i(amount_i),
        .left_i  (go_left),
        .arith_i (go_arith),
        .data_o  (word),
        .carry_o (out_bit)
    );

    shf_flags #(.WIDTH(WIDTH)) u_flags (
        .word_i (word),
        .carry_i(out_bit),
        .flags_o(flags)
    );

    assign result_o = word;
    assign zero_o   = flags.zero;
    assign sign_o   = flags.sign;
    assign carry_o  = flags.carry;
    assign ovf_o    = flags.ovf;

    // Chain output against direct shift operators.
    always_comb begin
        if (amount_i == '0) begin
            p_zero_amount_r6: assert (!carry_o && result_o == opnd_i);
        end
        unique case (op_sel)
            SHF_LSL: begin
                p_left_result_r1: assert (result_o == (opnd_i << amount_i));
            end
            SHF_LSR: begin
                p_right_result_r2: assert (result_o == (opnd_i >> amount_i));
            end
            SHF_ASR, SHF_ASR_ALT: begin
                p_arith_result_r3: assert (result_o == WIDTH'($signed(opnd_i) >>> amount_i));
            end
            default: ;
        endcase
        p_sign_tracks_r8: assert (sign_o == result_o[WIDTH-1]);
    end

endmodule

// File: tb/tb_shf_unit.sv
`timescale 1ns/1ps
module tb_shf_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [4:0]  amt;
    logic [1:0]  op;
    logic [31:0] res;
    logic        z, s, cy, ov;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    shf_unit dut (
        .opnd_i  (opnd),
        .amount_i(amt),
        .op_i    (op),
        .result_o(res),
        .zero_o  (z),
        .sign_o  (s),
        .carry_o (cy),
        .ovf_o   (ov)
    );

    function automatic logic [31:0] exp_res(logic [31:0] a, logic [4:0] n, logic [1:0] o);
        logic [31:0] r;
        r = a;
        for (int i = 0; i < int'(n); i++) begin
            if (o == 2'b00)      r = {r[30:0], 1'b0};
            else if (o == 2'b01) r = {1'b0, r[31:1]};
            else                 r = {a[31], r[31:1]};
        end
        return r;
    endfunction

    function automatic logic exp_cy(logic [31:0] a, logic [4:0] n, logic [1:0] o);
        if (n == 5'd0) return 1'b0;
        if (o == 2'b00) return a[32 - int'(n)];
        return a[int'(n) - 1];
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (opnd %h amt %0d op %b)",
                     tag, act, expv, opnd, amt, op);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [4:0] n, logic [1:0] o);
        logic [31:0] er;
        @(negedge clk);
        opnd = a; amt = n; op = o;
        @(posedge clk);
        #1;
        er = exp_res(a, n, o);
        if (n == 5'd0)         cmp("R6 result", res, a);
        else if (o == 2'b00)   cmp("R1 result", res, er);
        else if (o == 2'b01)   cmp("R2 result", res, er);
        else                   cmp("R3 result", res, er);
        if (n == 5'd0)         cmp("R6 carry", {31'd0, cy}, 32'd0);
        else if (o == 2'b00)   cmp("R4 carry", {31'd0, cy}, {31'd0, exp_cy(a, n, o)});
        else                   cmp("R5 carry", {31'd0, cy}, {31'd0, exp_cy(a, n, o)});
        cmp("R7 zero", {31'd0, z}, {31'd0, (er == 32'd0)});
        cmp("R8 sign", {31'd0, s}, {31'd0, er[31]});
        cmp("R9 ovf", {31'd0, ov}, 32'd0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        opnd = '0; amt = '0; op = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiet inputs: result 0, zero set, carry 0 (R6, R7).
        apply(32'h0, 5'd0, 2'b00);
        // Zero amount on every code (R6).
        for (int o = 0; o < 4; o++) apply(32'hFFFF_FFFF, 5'd0, 2'(o));
        // Single-bit extremes (R4, R5).
        apply(32'h8000_0000, 5'd1, 2'b00);
        apply(32'h0000_0002, 5'd31, 2'b00);
        apply(32'h0000_0001, 5'd1, 2'b01);
        apply(32'h4000_0000, 5'd31, 2'b01);
        // Arithmetic fill on both codes (R3).
        apply(32'h8000_0000, 5'd31, 2'b10);
        apply(32'h8000_0000, 5'd31, 2'b11);
        apply(32'h7FFF_FFFF, 5'd31, 2'b11);
        // Shifted out to zero (R7).
        apply(32'h0000_0001, 5'd1, 2'b01);
        apply(32'h8000_0000, 5'd1, 2'b00);
        // Sign from result (R8).
        apply(32'h4000_0000, 5'd1, 2'b00);
        // Random mix.
        for (int i = 0; i < 800; i++) begin
            apply($urandom(), 5'($urandom()), 2'($urandom()));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule